// File: doc/BRIEF.md
# Configurable 16-bit Timer/Counter Peripheral

This block is a 16-bit up-counter that sits on an 8-bit register bus. Software reaches three registers through a two-bit address: a control register at address 0, the low count byte at address 1 and the high count byte at address 2. Address 3 reads as zero and ignores writes. The counter advances from one of two sources. The internal source is a tick at one quarter of the system clock. The external source is the rising edges of an external clock pin, which can pass through a two-flop synchroniser or bypass it. A prescaler of 1, 2, 4 or 8 sits in front of the counter.

Wrapping from the all-ones count to zero sets a sticky interrupt flag, which a one-cycle acknowledge pulse clears. A special-event pulse from outside zeroes the count. Two control bits are brought out as a routing code that tells two capture/compare units whether to use this timer or the other timer as their timebase.

The count bytes can be accessed in two ways. In byte mode each byte is read and written on its own. In word mode the high byte is staged through a buffer, so that software sees and loads a coherent 16-bit value through two byte accesses.

Top module: `tmr16_periph`

## Requirements
- R1: After reset the control register, both count bytes, the interrupt flag and the routing code all read as zero.
- R2: Control bits 5:4 select the prescale. The values 00, 01, 10 and 11 select division by 1, 2, 4 and 8. With the internal source running (control bit 1 = 0, bit 0 = 1), the count advances by exactly N in 4·div·N clock cycles, counted from the control write.
- R3: With the run bit (control bit 0) at 0, the count holds its value under either source.
- R4: With control bit 1 at 1, the count advances on rising edges of ext_clk. The first rising edge after the block enters external mode is counted only if a falling edge has been seen since entry.
- R5: In external mode, control bit 2 = 1 bypasses the synchroniser. A raw rising edge then shows in the count after one clock edge. With bit 2 = 0 it shows after three clock edges.
- R6: In internal mode, control bit 2 has no effect on the count rate.
- R7: With control bit 7 at 0 (byte mode), a write to address 1 or address 2 changes only that byte of the count, and reads return the live bytes.
- R8: With control bit 7 at 1 (word mode), a read of address 1 copies the live high byte into a buffer, and reads of address 2 return that buffer. A write to address 2 loads only the buffer. The next write to address 1 loads {buffer, data} into the count in one cycle.
- R9: An increment from 0xFFFF to 0x0000 sets irq_flag. The flag stays set until an irq_ack pulse clears it. A new overflow in the same cycle as irq_ack wins.
- R10: A one-cycle evt_clear pulse zeroes the whole count on the next clock edge. It takes priority over a bus write and over an increment.
- R11: tb_sel equals {control bit 6, control bit 3}. 1x gives this timer to both units, 01 gives it to unit 2 only, and 00 gives it to neither.
- R12: Any write to addresses 0, 1 or 2 clears the prescaler's partial count. An increment due in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per access |
| rd_en | input | 1 | Bus read strobe; matters only for word-mode low-byte reads |
| addr | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational from addr |
| ext_clk | input | 1 | External count clock |
| evt_clear | input | 1 | Special-event pulse that zeroes the count |
| irq_ack | input | 1 | Pulse that clears the overflow flag |
| irq_flag | output | 1 | Sticky overflow interrupt flag |
| tb_sel | output | 2 | Timebase routing code for two capture/compare units |

## Verification
The bench sweeps all four prescale settings, with the synchroniser bit both set and clear, and checks that the count lands on an exact value at the end of a window measured from the control write. An off-by-one in the prescale compare, or a sync bit that leaked into internal mode, would miss that value. In external mode it sends a rising edge before any falling edge, which a design without the edge qualifier would count. It also measures the latency of a single edge with the synchroniser and without it, which catches a missing or extra synchroniser stage. Word-mode tests zero the live count between a low-byte read and a high-byte read to prove the buffer is used, and write the high byte alone to show it does not reach the count. A restart of the prescaler partway through a period must delay the next increment by a full period, and wrapping from 0xFFFE must leave the flag set until it is acknowledged.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    REG_CTL = 2'd0,
    REG_LO  = 2'd1,
    REG_HI  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CB_RUN   = 0;
  localparam int CB_EXT   = 1;
  localparam int CB_NOSYN = 2;
  localparam int CB_TB1   = 3;
  localparam int CB_PS_LO = 4;
  localparam int CB_PS_HI = 5;
  localparam int CB_TB2   = 6;
  localparam int CB_WORD  = 7;

  function automatic logic [1:0] route_code(input logic [7:0] ctl);
    return {ctl[CB_TB2], ctl[CB_TB1]};
  endfunction

  function automatic logic [1:0] ps_code(input logic [7:0] ctl);
    return {ctl[CB_PS_HI], ctl[CB_PS_LO]};
  endfunction

endpackage

// File: rtl/tmr16_src.sv
module tmr16_src #(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_ext,
  input  logic sync_bypass,
  output logic src_tick
);
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          int_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic          ext_sel;
  logic          ext_prev;
  logic          ext_rise;
  logic          ext_fall;
  logic          armed_q;

  // free-running quarter-rate tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == DW'(INT_DIV - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
  assign int_tick = (div_q == DW'(INT_DIV - 1));

  // synchroniser chain
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else sync_q[0] <= ext_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign ext_sel = sync_bypass ? ext_clk : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b0;
    else ext_prev <= ext_sel;
  end

  assign ext_rise = ext_sel & ~ext_prev;
  assign ext_fall = ~ext_sel & ext_prev;

  // a falling edge must be seen after entering external mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (!src_ext) armed_q <= 1'b0;
    else if (ext_fall) armed_q <= 1'b1;
  end

  assign src_tick = src_ext ? (ext_rise & armed_q) : int_tick;

endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int PS_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_in,
  input  logic [PS_SEL_W-1:0] ps_sel,
  input  logic                clr,
  output logic                inc
);
  localparam int PCW = (1 << PS_SEL_W) - 1;

  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] limit;
  logic           at_limit;

  assign limit    = (PCW'(1) << ps_sel) - PCW'(1);
  assign at_limit = (pcnt_q == limit);
  assign inc      = evt_in & at_limit & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (clr) pcnt_q <= '0;
    else if (evt_in) pcnt_q <= at_limit ? '0 : pcnt_q + 1'b1;
  end

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              evt_clear,
  input  logic              inc,
  input  logic              irq_ack,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic [BYTE_W-1:0] hbuf_q,
  output logic              cnt_wr,
  output logic              ovf_evt,
  output logic              irq_flag
);
  localparam int CW = 2 * BYTE_W;

  logic [CW-1:0] cnt_d;

  assign cnt_wr  = wr_lo | (wr_hi & ~word_mode);
  assign ovf_evt = inc & (cnt_q == {CW{1'b1}}) & ~evt_clear & ~cnt_wr;

  always_comb begin
    cnt_d = cnt_q;
    if (evt_clear) cnt_d = '0;
    else if (wr_lo) cnt_d = word_mode ? {hbuf_q, wdata} : {cnt_q[CW-1:BYTE_W], wdata};
    else if (wr_hi && !word_mode) cnt_d = {wdata, cnt_q[BYTE_W-1:0]};
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hbuf_q <= '0;
    else if (word_mode && wr_hi) hbuf_q <= wdata;
    else if (word_mode && rd_lo) hbuf_q <= cnt_q[CW-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag <= 1'b0;
    else if (ovf_evt) irq_flag <= 1'b1;
    else if (irq_ack) irq_flag <= 1'b0;
  end

endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
  import tmr16_pkg::*;
#(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_clk,
  input  logic       evt_clear,
  input  logic       irq_ack,
  output logic       irq_flag,
  output logic [1:0] tb_sel
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  logic [7:0]       ctl_q;
  logic             wr_ctl, wr_lo, wr_hi, rd_lo;
  logic             presc_clr;
  logic             run;
  logic             src_tick;
  logic             cnt_evt;
  logic             inc_pulse;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] hbuf_q;
  logic             cnt_wr;
  logic             ovf_evt;
  logic             word_mode;

  assign wr_ctl    = wr_en & (addr == REG_CTL);
  assign wr_lo     = wr_en & (addr == REG_LO);
  assign wr_hi     = wr_en & (addr == REG_HI);
  assign rd_lo     = rd_en & (addr == REG_LO);
  assign presc_clr = wr_ctl | wr_lo | wr_hi;
  assign run       = ctl_q[CB_RUN];
  assign word_mode = ctl_q[CB_WORD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata;
  end

  tmr16_src #(
    .INT_DIV     (INT_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_clk     (ext_clk),
    .src_ext     (ctl_q[CB_EXT]),
    .sync_bypass (ctl_q[CB_NOSYN]),
    .src_tick    (src_tick)
  );

  assign cnt_evt = run & src_tick;

  tmr16_presc #(
    .PS_SEL_W (2)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (cnt_evt),
    .ps_sel (ps_code(ctl_q)),
    .clr    (presc_clr),
    .inc    (inc_pulse)
  );

  tmr16_count #(
    .BYTE_W (BYTE_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_mode (word_mode),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_lo     (rd_lo),
    .wdata     (wdata),
    .evt_clear (evt_clear),
    .inc       (inc_pulse),
    .irq_ack   (irq_ack),
    .cnt_q     (cnt_q),
    .hbuf_q    (hbuf_q),
    .cnt_wr    (cnt_wr),
    .ovf_evt   (ovf_evt),
    .irq_flag  (irq_flag)
  );

  always_comb begin
    unique case (addr)
      REG_CTL: rdata = ctl_q;
      REG_LO:  rdata = cnt_q[BYTE_W-1:0];
      REG_HI:  rdata = word_mode ? hbuf_q : cnt_q[CNT_W-1:BYTE_W];
      default: rdata = '0;
    endcase
  end

  assign tb_sel = route_code(ctl_q);

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [7:0]       wdata,
  input logic             evt_clear,
  input logic             irq_ack,
  input logic             irq_flag,
  input logic [1:0]       tb_sel,
  input logic             run,
  input logic [CNT_W-1:0] cnt_q,
  input logic             inc_pulse,
  input logic             cnt_wr,
  input logic             ovf_evt
);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse && !evt_clear && !cnt_wr |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !evt_clear && !cnt_wr |=> $stable(cnt_q));

  p_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pulse && (cnt_q == {CNT_W{1'b1}}) && !evt_clear && !cnt_wr |=> irq_flag && (cnt_q == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_ack |=> irq_flag);

  p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(ovf_evt));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> cnt_q == '0);

  p_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 2'd0) |=> tb_sel == {$past(wdata[6]), $past(wdata[3])});

  p_presc_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr != 2'd3) |-> !inc_pulse);

endmodule

bind tmr16_periph tmr16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .evt_clear (evt_clear),
  .irq_ack   (irq_ack),
  .irq_flag  (irq_flag),
  .tb_sel    (tb_sel),
  .run       (run),
  .cnt_q     (cnt_q),
  .inc_pulse (inc_pulse),
  .cnt_wr    (cnt_wr),
  .ovf_evt   (ovf_evt)
);

// File: tb/test_tmr16_periph.sv
module test_tmr16_periph;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_clk = 1'b0;
  logic       evt_clear = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_flag;
  logic [1:0] tb_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tmr16_periph i_tmr16_periph (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .evt_clear(evt_clear),
    .irq_ack(irq_ack), .irq_flag(irq_flag), .tb_sel(tb_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the access takes effect at the following posedge
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 ctl", v, 0);
    bus_rd(2'd1, v); chk("R1 lo", v, 0);
    bus_rd(2'd2, v); chk("R1 hi", v, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 tb_sel", tb_sel, 0);

    // R2 and R6: sweep prescale and sync bit on internal source
    for (int ps = 0; ps < 4; ps++) begin
      for (int sb = 0; sb < 2; sb++) begin
        int n;
        n = ps + 2;
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'((ps << 4) | (sb << 2) | 1));
        repeat (4 * (1 << ps) * n) @(negedge clk);
        bus_rd(2'd1, v);
        if (sb == 0) chk($sformatf("R2 ps=%0d", ps), v, 16'(n));
        else chk($sformatf("R6 ps=%0d sync bit set", ps), v, 16'(n));
        bus_wr(2'd0, 8'h00);
      end
    end

    // R7 byte mode independent bytes
    bus_wr(2'd1, 8'h34);
    bus_wr(2'd2, 8'h12);
    bus_rd(2'd1, v); chk("R7 lo", v, 16'h34);
    bus_rd(2'd2, v); chk("R7 hi", v, 16'h12);
    bus_wr(2'd1, 8'hAB);
    bus_rd(2'd2, v); chk("R7 hi untouched", v, 16'h12);
    bus_rd(2'd1, v); chk("R7 lo new", v, 16'hAB);

    // R3 hold with run off, internal then external
    bus_wr(2'd0, 8'h30);
    repeat (100) @(negedge clk);
    bus_rd(2'd1, v); chk("R3 hold lo int", v, 16'hAB);
    bus_rd(2'd2, v); chk("R3 hold hi int", v, 16'h12);
    bus_wr(2'd0, 8'h06);
    ext_pulse(); ext_pulse(); ext_pulse();
    bus_rd(2'd1, v); chk("R3 hold lo ext", v, 16'hAB);

    // R4 external edges with falling-edge qualifier
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd0, 8'h07);
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd1, v); chk("R4 first rise not counted", v, 0);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    ext_pulse();
    bus_rd(2'd1, v); chk("R4 rise after fall", v, 1);
    for (int k = 0; k < 4; k++) ext_pulse();
    repeat (20) @(negedge clk);
    bus_rd(2'd1, v); chk("R4 five edges, no internal ticks", v, 5);

    // R5 latency bypass vs synchroniser (already armed)
    bus_wr(2'd1, 8'h00);
    ext_clk = 1'b1;
    @(negedge clk);
    bus_rd(2'd1, v); chk("R5 bypass one edge", v, 1);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr(2'd0, 8'h03);
    bus_wr(2'd1, 8'h00);
    repeat (4) @(negedge clk);
    ext_clk = 1'b1;
    @(negedge clk);
    bus_rd(2'd1, v); chk("R5 sync after 1 edge", v, 0);
    bus_rd(2'd1, v); chk("R5 sync after 2 edges", v, 0);
    bus_rd(2'd1, v); chk("R5 sync after 3 edges", v, 1);
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
    bus_wr(2'd0, 8'h00);

    // R8 word mode buffering
    bus_wr(2'd1, 8'h34);
    bus_wr(2'd2, 8'h12);
    bus_wr(2'd0, 8'h80);
    bus_wr(2'd2, 8'h56);
    bus_rd(2'd1, v); chk("R8 lo unchanged by hi write", v, 16'h34);
    bus_rd(2'd2, v); chk("R8 hi latched live", v, 16'h12);
    bus_wr(2'd2, 8'h56);
    bus_wr(2'd1, 8'h78);
    bus_rd(2'd1, v); bus_rd(2'd2, v2);
    chk("R8 word commit", {v2, v}, 16'h5678);
    bus_rd(2'd1, v);
    evt_clear = 1'b1; @(negedge clk); evt_clear = 1'b0;
    bus_rd(2'd2, v2); chk("R8 hi from buffer after clear", v2, 16'h56);
    bus_rd(2'd1, v); bus_rd(2'd2, v2);
    chk("R8 fresh latch after clear", {v2, v}, 16'h0000);
    bus_wr(2'd0, 8'h00);

    // R10 special event clear with stopped timer
    bus_wr(2'd1, 8'h21);
    bus_wr(2'd2, 8'h43);
    evt_clear = 1'b1; @(negedge clk); evt_clear = 1'b0;
    bus_rd(2'd1, v); bus_rd(2'd2, v2);
    chk("R10 clear", {v2, v}, 16'h0000);

    // R9 overflow flag
    bus_wr(2'd1, 8'hFE);
    bus_wr(2'd2, 8'hFF);
    chk("R9 flag clear before wrap", irq_flag, 0);
    bus_wr(2'd0, 8'h01);
    repeat (12) @(negedge clk);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd1, v); bus_rd(2'd2, v2);
    chk("R9 count wrapped", {v2, v}, 16'h0001);
    chk("R9 flag set", irq_flag, 1);
    repeat (20) @(negedge clk);
    chk("R9 flag sticky", irq_flag, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R9 flag acked", irq_flag, 0);

    // R11 routing code
    bus_wr(2'd0, 8'h40); chk("R11 code 10", tb_sel, 2'b10);
    bus_wr(2'd0, 8'h08); chk("R11 code 01", tb_sel, 2'b01);
    bus_wr(2'd0, 8'h48); chk("R11 code 11", tb_sel, 2'b11);
    bus_wr(2'd0, 8'h00); chk("R11 code 00", tb_sel, 2'b00);

    // R12 prescaler restart on control write
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd0, 8'h31);
    repeat (16) @(negedge clk);
    bus_wr(2'd0, 8'h31);
    repeat (28) @(negedge clk);
    bus_rd(2'd1, v); chk("R12 no early increment", v, 0);
    repeat (3) @(negedge clk);
    bus_rd(2'd1, v); chk("R12 full period after restart", v, 1);
    bus_wr(2'd0, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule